// File: doc/BRIEF.md
# Next-PC and Return-Stack Sequencer

This unit picks the program counter that an 8-bit controller with a 16-bit code space runs next. The decoder supplies a branch kind together with these inputs:
- the address of the instruction that follows;
- the operand fields (a 16-bit target, an 11-bit page target, a signed 8-bit displacement);
- the accumulator and the 16-bit data pointer;
- two 8-bit condition operands.

The unit returns the next PC, a taken flag and a single-cycle `done` strobe. For the decrement-and-branch kind it also returns the decremented operand. For the compare-and-branch kind it also returns a carry result. For the table-lookup kinds it returns a code-read address.

Calls and returns go through an 8-bit stack pointer. The 16-bit return address crosses an external byte-wide memory port one byte per cycle. Read data on that port arrives one cycle after the read strobe. While a stack sequence is running, the unit reports busy and does not accept new work.

Top module: `npc_sequencer`

## Requirements
- R1: While reset is held, and after it is released, `pc_out` is 0000h and `sp_out` is 07h. `done`, `mem_we`, `mem_re`, `code_rd`, `dec_we` and `carry_we` are all 0.
- R2: Kind 0 (sequential) sets `pc_out` to `pc_seq` with `taken`=0. `done` rises one cycle after the operation is accepted. This applies to all single-cycle kinds.
- R3: Kind 1 (long jump) sets `pc_out` to `imm_long`, with `taken`=1.
- R4: Kind 2 (page jump) sets `pc_out` to `{pc_seq[15:11], imm_page}`, so the target stays in the 2 KB page of the following instruction.
- R5: Kind 3 (relative jump) sets `pc_out` to `pc_seq` plus the sign-extended `rel_off`, which ranges from -128 to +127. The sum wraps modulo 2^16.
- R6: Kind 4 jumps to `dptr + acc`. Kinds 12 and 13 pulse `code_rd` and set `code_addr` to `dptr + acc` and `pc_seq + acc` respectively, leaving `pc_out` = `pc_seq`. All sums are modulo 2^16.
- R7: Kind 5 branches to the relative target when `acc` is zero. Kind 6 branches when `acc` is non-zero. Otherwise `pc_out` is `pc_seq`.
- R8: Kind 7 outputs `dec_out` = `opnd_a` - 1 (mod 256) with a `dec_we` pulse. It branches to the relative target exactly when that result is non-zero.
- R9: Kind 8 branches to the relative target when `opnd_a` differs from `opnd_b`. It pulses `carry_we` with `carry_out` = 1 exactly when `opnd_a` < `opnd_b`, compared as unsigned values.
- R10: Kinds 9 (long call) and 10 (page call) each perform two pushes on consecutive cycles. The first writes `pc_seq[7:0]` at SP+1 and the second writes `pc_seq[15:8]` at SP+2. Each push first increments SP and then writes. `done` follows with `pc_out` set to the R3 or R4 target.
- R11: Kind 11 (return) first reads the high byte at SP, then the low byte at SP-1, decrementing SP after each read. `pc_out` becomes `{high, low}` and `done` is raised.
- R12: `busy` is high during stack sequences, and `op_valid` is ignored while `busy` is high. `mem_we`, `mem_re` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request, taken when not busy |
| op_kind | input | 4 | Branch kind code (R2 to R11) |
| pc_seq | input | 16 | Address of the following instruction |
| imm_long | input | 16 | Absolute 16-bit target |
| imm_page | input | 11 | In-page target bits |
| rel_off | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| opnd_a | input | 8 | Decrement operand, or first compare operand |
| opnd_b | input | 8 | Second compare operand |
| mem_rdata | input | 8 | Stack memory read data, one cycle after `mem_re` |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | Result valid for one cycle |
| pc_out | output | 16 | Next program counter |
| taken | output | 1 | Control transfer happened |
| dec_we | output | 1 | Decremented operand valid |
| dec_out | output | 8 | Decremented operand |
| carry_we | output | 1 | Compare carry valid |
| carry_out | output | 1 | Unsigned less-than result |
| code_rd | output | 1 | Table read request |
| code_addr | output | 16 | Table read address |
| sp_out | output | 8 | Stack pointer |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |

## Verification
The bench builds the unit with its default sizes: a 16-bit PC, an 8-bit data path, an 11-bit page field and an 8-bit stack pointer. At these sizes every displacement, every accumulator value and every decrement operand can be swept completely. The sweeps cover wrap at both ends of the address space, page targets across the full 11-bit field, and a dense grid of compare pairs. Nested calls and returns run against a byte memory model in the bench, so the byte order and the SP step can be observed directly.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    K_SEQ    = 4'd0,
    K_LONG   = 4'd1,
    K_PAGE   = 4'd2,
    K_REL    = 4'd3,
    K_INDIR  = 4'd4,
    K_JZ     = 4'd5,
    K_JNZ    = 4'd6,
    K_DJNZ   = 4'd7,
    K_CJNE   = 4'd8,
    K_CALL_L = 4'd9,
    K_CALL_P = 4'd10,
    K_RET    = 4'd11,
    K_TBL_DP = 4'd12,
    K_TBL_PC = 4'd13
  } npc_kind_e;
endpackage

// File: rtl/npc_target.sv
module npc_target #(
  parameter int PC_W   = 16,
  parameter int D_W    = 8,
  parameter int PAGE_W = 11
) (
  input  logic [PC_W-1:0]   pc_seq,
  input  logic [PAGE_W-1:0] imm_page,
  input  logic [D_W-1:0]    rel_off,
  input  logic [D_W-1:0]    acc,
  input  logic [PC_W-1:0]   dptr,
  output logic [PC_W-1:0]   t_page,
  output logic [PC_W-1:0]   t_rel,
  output logic [PC_W-1:0]   t_indir,
  output logic [PC_W-1:0]   t_tbl_pc
);
  localparam int EXT_W = PC_W - D_W;

  logic [PC_W-1:0] rel_sx;
  logic [PC_W-1:0] acc_zx;

  assign rel_sx   = {{EXT_W{rel_off[D_W-1]}}, rel_off};
  assign acc_zx   = {{EXT_W{1'b0}}, acc};
  assign t_rel    = pc_seq + rel_sx;
  assign t_indir  = dptr + acc_zx;
  assign t_tbl_pc = pc_seq + acc_zx;

  generate
    if (PAGE_W < PC_W) begin : g_paged
      assign t_page = {pc_seq[PC_W-1:PAGE_W], imm_page};
    end else begin : g_flat
      assign t_page = imm_page[PC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int D_W = 8
) (
  input  npc_kind_e      kind,
  input  logic [D_W-1:0] acc,
  input  logic [D_W-1:0] opnd_a,
  input  logic [D_W-1:0] opnd_b,
  output logic           cond_taken,
  output logic [D_W-1:0] dec_val,
  output logic           lt_flag
);
  assign dec_val = opnd_a - D_W'(1);
  assign lt_flag = (opnd_a < opnd_b);

  always_comb begin
    case (kind)
      K_JZ:    cond_taken = (acc == '0);
      K_JNZ:   cond_taken = (acc != '0);
      K_DJNZ:  cond_taken = (dec_val != '0);
      K_CJNE:  cond_taken = (opnd_a != opnd_b);
      default: cond_taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_stack.sv
module npc_stack #(
  parameter int                PC_W   = 16,
  parameter int                D_W    = 8,
  parameter int                SP_W   = 8,
  parameter logic [SP_W-1:0]   SP_RST = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_call,
  input  logic            start_ret,
  input  logic [PC_W-1:0] ret_addr,
  input  logic [D_W-1:0]  mem_rdata,
  output logic            busy,
  output logic            push_fin,
  output logic            pop_fin,
  output logic [PC_W-1:0] pop_addr,
  output logic [SP_W-1:0] sp,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [D_W-1:0]  mem_wdata
);
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO, S_POP_FIN
  } stk_state_e;

  stk_state_e      st;
  logic [PC_W-1:0] ret_q;
  logic [D_W-1:0]  hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      sp    <= SP_RST;
      ret_q <= '0;
      hi_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_call) begin
            ret_q <= ret_addr;
            st    <= S_PUSH_LO;
          end else if (start_ret) begin
            st <= S_POP_HI;
          end
        end
        S_PUSH_LO: begin
          sp <= sp + SP_W'(1);
          st <= S_PUSH_HI;
        end
        S_PUSH_HI: begin
          sp <= sp + SP_W'(1);
          st <= S_IDLE;
        end
        S_POP_HI: begin
          sp <= sp - SP_W'(1);
          st <= S_POP_LO;
        end
        S_POP_LO: begin
          hi_q <= mem_rdata;
          sp   <= sp - SP_W'(1);
          st   <= S_POP_FIN;
        end
        S_POP_FIN: st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_we    = (st == S_PUSH_LO) || (st == S_PUSH_HI);
  assign mem_re    = (st == S_POP_HI) || (st == S_POP_LO);
  assign mem_addr  = mem_we ? (sp + SP_W'(1)) : sp;
  assign mem_wdata = (st == S_PUSH_LO) ? ret_q[D_W-1:0] : ret_q[PC_W-1:D_W];
  assign push_fin  = (st == S_PUSH_HI);
  assign pop_fin   = (st == S_POP_FIN);
  assign pop_addr  = {hi_q, mem_rdata};
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int              PC_W   = 16,
  parameter int              D_W    = 8,
  parameter int              PAGE_W = 11,
  parameter int              SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_kind,
  input  logic [PC_W-1:0]   pc_seq,
  input  logic [PC_W-1:0]   imm_long,
  input  logic [PAGE_W-1:0] imm_page,
  input  logic [D_W-1:0]    rel_off,
  input  logic [D_W-1:0]    acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic [D_W-1:0]    opnd_a,
  input  logic [D_W-1:0]    opnd_b,
  input  logic [D_W-1:0]    mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   pc_out,
  output logic              taken,
  output logic              dec_we,
  output logic [D_W-1:0]    dec_out,
  output logic              carry_we,
  output logic              carry_out,
  output logic              code_rd,
  output logic [PC_W-1:0]   code_addr,
  output logic [SP_W-1:0]   sp_out,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SP_W-1:0]   mem_addr,
  output logic [D_W-1:0]    mem_wdata
);
  npc_kind_e       kind;
  logic            accept;
  logic [PC_W-1:0] t_page, t_rel, t_indir, t_tbl_pc;
  logic            cond_taken, lt_flag;
  logic [D_W-1:0]  dec_val;
  logic            start_call, start_ret;
  logic            push_fin, pop_fin;
  logic [PC_W-1:0] pop_addr;
  logic [PC_W-1:0] call_tgt;

  assign kind       = npc_kind_e'(op_kind);
  assign accept     = op_valid && !busy;
  assign start_call = accept && (kind == K_CALL_L || kind == K_CALL_P);
  assign start_ret  = accept && (kind == K_RET);

  npc_target #(.PC_W(PC_W), .D_W(D_W), .PAGE_W(PAGE_W)) u_target (
    .pc_seq  (pc_seq),
    .imm_page(imm_page),
    .rel_off (rel_off),
    .acc     (acc),
    .dptr    (dptr),
    .t_page  (t_page),
    .t_rel   (t_rel),
    .t_indir (t_indir),
    .t_tbl_pc(t_tbl_pc)
  );

  npc_cond #(.D_W(D_W)) u_cond (
    .kind      (kind),
    .acc       (acc),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cond_taken(cond_taken),
    .dec_val   (dec_val),
    .lt_flag   (lt_flag)
  );

  npc_stack #(.PC_W(PC_W), .D_W(D_W), .SP_W(SP_W), .SP_RST(SP_RST)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .start_call(start_call),
    .start_ret (start_ret),
    .ret_addr  (pc_seq),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .push_fin  (push_fin),
    .pop_fin   (pop_fin),
    .pop_addr  (pop_addr),
    .sp        (sp_out),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      done      <= 1'b0;
      taken     <= 1'b0;
      dec_we    <= 1'b0;
      dec_out   <= '0;
      carry_we  <= 1'b0;
      carry_out <= 1'b0;
      code_rd   <= 1'b0;
      code_addr <= '0;
      call_tgt  <= '0;
    end else begin
      done     <= 1'b0;
      dec_we   <= 1'b0;
      carry_we <= 1'b0;
      code_rd  <= 1'b0;
      if (accept) begin
        case (kind)
          K_LONG:   begin pc_out <= imm_long; taken <= 1'b1; done <= 1'b1; end
          K_PAGE:   begin pc_out <= t_page;   taken <= 1'b1; done <= 1'b1; end
          K_REL:    begin pc_out <= t_rel;    taken <= 1'b1; done <= 1'b1; end
          K_INDIR:  begin pc_out <= t_indir;  taken <= 1'b1; done <= 1'b1; end
          K_JZ, K_JNZ, K_DJNZ, K_CJNE: begin
            pc_out <= cond_taken ? t_rel : pc_seq;
            taken  <= cond_taken;
            done   <= 1'b1;
            if (kind == K_DJNZ) begin
              dec_out <= dec_val;
              dec_we  <= 1'b1;
            end
            if (kind == K_CJNE) begin
              carry_out <= lt_flag;
              carry_we  <= 1'b1;
            end
          end
          K_CALL_L: call_tgt <= imm_long;
          K_CALL_P: call_tgt <= t_page;
          K_RET:    ;
          K_TBL_DP: begin
            code_addr <= t_indir; code_rd <= 1'b1;
            pc_out <= pc_seq; taken <= 1'b0; done <= 1'b1;
          end
          K_TBL_PC: begin
            code_addr <= t_tbl_pc; code_rd <= 1'b1;
            pc_out <= pc_seq; taken <= 1'b0; done <= 1'b1;
          end
          default:  begin pc_out <= pc_seq; taken <= 1'b0; done <= 1'b1; end
        endcase
      end else if (push_fin) begin
        pc_out <= call_tgt;
        taken  <= 1'b1;
        done   <= 1'b1;
      end else if (pop_fin) begin
        pc_out <= pop_addr;
        taken  <= 1'b1;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk #(
  parameter int D_W  = 8,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic            taken,
  input logic            dec_we,
  input logic [D_W-1:0]  dec_out,
  input logic            carry_we,
  input logic            carry_out,
  input logic [SP_W-1:0] sp_out,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr
);
  // R10
  push_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == SP_W'(sp_out + SP_W'(1)));

  // R10
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> sp_out == SP_W'($past(sp_out) + SP_W'(1)));

  // R11
  pop_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> mem_addr == sp_out);

  // R11
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> sp_out == SP_W'($past(sp_out) - SP_W'(1)));

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !mem_re) |=> $stable(sp_out));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re, done}));

  // R8
  djnz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    dec_we |-> (taken == (dec_out != '0)));

  // R9
  cjne_lt_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_we && carry_out) |-> taken);
endmodule

bind npc_sequencer npc_sequencer_chk #(.D_W(D_W), .SP_W(SP_W)) u_npc_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .taken    (taken),
  .dec_we   (dec_we),
  .dec_out  (dec_out),
  .carry_we (carry_we),
  .carry_out(carry_out),
  .sp_out   (sp_out),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr)
);

// File: tb/test_npc_sequencer.sv
module test_npc_sequencer;
  import npc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_kind = '0;
  logic [15:0] pc_seq = '0, imm_long = '0, dptr = '0;
  logic [10:0] imm_page = '0;
  logic [7:0]  rel_off = '0, acc = '0, opnd_a = '0, opnd_b = '0;
  logic [7:0]  mem_rdata;
  logic        busy, done, taken, dec_we, carry_we, carry_out, code_rd;
  logic [15:0] pc_out, code_addr;
  logic [7:0]  dec_out, sp_out, mem_addr, mem_wdata;
  logic        mem_we, mem_re;

  logic [7:0]  stk_mem [256];
  logic [7:0]  rd_q = '0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) stk_mem[mem_addr] <= mem_wdata;
    if (mem_re) rd_q <= stk_mem[mem_addr];
  end
  assign mem_rdata = rd_q;

  npc_sequencer i_npc_sequencer (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .pc_seq(pc_seq), .imm_long(imm_long), .imm_page(imm_page),
    .rel_off(rel_off), .acc(acc), .dptr(dptr), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_out(pc_out), .taken(taken), .dec_we(dec_we), .dec_out(dec_out),
    .carry_we(carry_we), .carry_out(carry_out), .code_rd(code_rd),
    .code_addr(code_addr), .sp_out(sp_out), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rel_tgt(logic [15:0] pc, logic [7:0] r);
    return pc + {{8{r[7]}}, r};
  endfunction

  // Issue a single-cycle kind; returns at the negedge where results are visible.
  task automatic one_op(npc_kind_e k);
    op_kind  = k;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_call(npc_kind_e k, logic [15:0] pc, logic [15:0] exp_tgt, bit intrude);
    logic [7:0] sp0;
    sp0 = sp_out;
    pc_seq = pc;
    one_op(k);
    chk("R10 push lo we", {mem_we, busy}, 2'b11);
    chk("R10 push lo addr/data", {mem_addr, mem_wdata}, {sp0 + 8'd1, pc[7:0]});
    if (intrude) begin
      op_kind  = 4'(K_LONG);
      imm_long = 16'hDEAD;
      op_valid = 1'b1;
    end
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 push hi addr/data", {mem_we, mem_addr, mem_wdata}, {1'b1, sp0 + 8'd2, pc[15:8]});
    chk("R12 no done while busy", done, 1'b0);
    @(negedge clk);
    chk("R10 call done/pc", {done, taken, pc_out}, {2'b11, exp_tgt});
    chk("R10 sp after call", sp_out, sp0 + 8'd2);
    chk("R10 stack bytes", {stk_mem[sp0 + 8'd2], stk_mem[sp0 + 8'd1]}, pc);
    @(negedge clk);
    chk("R12 intruding op ignored", {done, pc_out}, {1'b0, exp_tgt});
  endtask

  task automatic do_ret(logic [15:0] exp_pc);
    logic [7:0] sp0;
    sp0 = sp_out;
    one_op(K_RET);
    chk("R11 pop hi", {mem_re, mem_addr}, {1'b1, sp0});
    @(negedge clk);
    chk("R11 pop lo", {mem_re, mem_addr}, {1'b1, sp0 - 8'd1});
    @(negedge clk);
    chk("R11 no done yet", done, 1'b0);
    @(negedge clk);
    chk("R11 return pc", {done, pc_out}, {1'b1, exp_pc});
    chk("R11 sp after ret", sp_out, sp0 - 8'd2);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pcs [5];
    logic [15:0] e;
    pcs = '{16'h0000, 16'h0005, 16'h7FF0, 16'hFFF0, 16'hFF80};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pc/sp", {pc_out, sp_out}, {16'h0000, 8'h07});
    chk("R1 reset strobes", {done, mem_we, mem_re, code_rd, dec_we, carry_we, busy}, 7'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {pc_out, sp_out, done}, {16'h0000, 8'h07, 1'b0});

    // R2 sequential
    for (int i = 0; i < 8; i++) begin
      pc_seq = 16'(i * 16'h2351);
      one_op(K_SEQ);
      chk("R2 sequential", {done, taken, pc_out}, {2'b10, pc_seq});
    end

    // R3 long
    for (int i = 0; i < 16; i++) begin
      imm_long = 16'(i * 16'h1111 + 16'h0F0F);
      one_op(K_LONG);
      chk("R3 long jump", {done, taken, pc_out}, {2'b11, imm_long});
    end

    // R4 page
    for (int p = 0; p < 32; p++) begin
      for (int a = 0; a < 2048; a += 97) begin
        pc_seq   = {5'(p), 11'(a ^ 11'h5A5)};
        imm_page = 11'(a);
        one_op(K_PAGE);
        chk("R4 page jump", pc_out, {5'(p), 11'(a)});
      end
    end
    pc_seq = 16'hF7FF; imm_page = 11'h7FF;
    one_op(K_PAGE);
    chk("R4 page top", pc_out, 16'hF7FF);

    // R5 relative, full offset sweep
    foreach (pcs[j]) begin
      for (int r = 0; r < 256; r++) begin
        pc_seq = pcs[j]; rel_off = 8'(r);
        one_op(K_REL);
        chk("R5 relative", {taken, pc_out}, {1'b1, rel_tgt(pcs[j], 8'(r))});
      end
    end

    // R6 indirect and table reads
    for (int a = 0; a < 256; a++) begin
      acc = 8'(a); dptr = 16'hFFC0; pc_seq = 16'hFFA0;
      one_op(K_INDIR);
      e = 16'hFFC0 + 16'(a);
      chk("R6 indirect jump", pc_out, e);
      one_op(K_TBL_DP);
      chk("R6 table dptr", {code_rd, code_addr, pc_out, taken}, {1'b1, e, 16'hFFA0, 1'b0});
      one_op(K_TBL_PC);
      chk("R6 table pc", {code_rd, code_addr}, {1'b1, 16'(16'hFFA0 + 16'(a))});
    end
    acc = 8'h80; dptr = 16'h2000;
    one_op(K_TBL_DP);
    chk("R6 table example", code_addr, 16'h2080);
    @(negedge clk);
    chk("R6 code_rd pulse", code_rd, 1'b0);

    // R7 zero tests
    pc_seq = 16'h4000; rel_off = 8'hF0;
    for (int a = 0; a < 256; a++) begin
      acc = 8'(a);
      one_op(K_JZ);
      chk("R7 jz", {taken, pc_out}, (a == 0) ? {1'b1, 16'h3FF0} : {1'b0, 16'h4000});
      one_op(K_JNZ);
      chk("R7 jnz", {taken, pc_out}, (a != 0) ? {1'b1, 16'h3FF0} : {1'b0, 16'h4000});
    end

    // R8 decrement and branch
    pc_seq = 16'h0010; rel_off = 8'h7F;
    for (int a = 0; a < 256; a++) begin
      opnd_a = 8'(a);
      one_op(K_DJNZ);
      chk("R8 djnz value", {dec_we, dec_out}, {1'b1, 8'(a - 1)});
      chk("R8 djnz branch", {taken, pc_out}, (a != 1) ? {1'b1, 16'h008F} : {1'b0, 16'h0010});
    end

    // R9 compare and branch
    pc_seq = 16'h8000; rel_off = 8'h80;
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        opnd_a = 8'(a); opnd_b = 8'(b);
        one_op(K_CJNE);
        chk("R9 cjne carry", {carry_we, carry_out}, {1'b1, a < b});
        chk("R9 cjne branch", {taken, pc_out}, (a != b) ? {1'b1, 16'h7F80} : {1'b0, 16'h8000});
      end
    end
    opnd_a = 8'h55; opnd_b = 8'h55;
    one_op(K_CJNE);
    chk("R9 cjne equal", {taken, carry_out}, 2'b00);

    // R10, R11, R12 nested calls and returns
    imm_long = 16'hABCD;
    do_call(K_CALL_L, 16'h1234, 16'hABCD, 1'b1);
    imm_page = 11'h3C5;
    do_call(K_CALL_P, 16'hE801, 16'hEBC5, 1'b0);
    imm_long = 16'h00FF;
    do_call(K_CALL_L, 16'hFFFF, 16'h00FF, 1'b1);
    do_ret(16'hFFFF);
    do_ret(16'hE801);
    do_ret(16'h1234);
    chk("R11 sp restored", sp_out, 8'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule